// File: doc/BRIEF.md
# Lockstep Compare Supervisor

This block supervises two lockstep comparators that watch a pair of CPU cores running in step. Software drives it through a small register write port and reads it back through a registered read port. One control write can enable comparison, start a self-test or fire a one-cycle error-force pulse into either comparator's error path. The block keeps a status word. It holds the lockstep-mode strap as seen by the block, a latched compare failure, a sticky debugger-attached flag, and the active, done and pass flags of the self-test. It also holds done and pass flags for each error-force run.

The self-test injects a mismatch into comparator 1 and waits a fixed window for that comparator to report it. It then does the same with comparator 2. The run stops at the first step that gets no report. A passing error-force run raises a one-cycle NMI pulse.

A start is dropped while any failure is pending, while a previous result of the same test is not yet cleared, or while comparison is disabled. An error-force start is also dropped while a debugger is attached. Status flags are cleared by write-one-to-clear. When a clear and a hardware set reach a flag in the same cycle, the clear wins.

Top module: `lockstep_supervisor`

## Requirements
- R1: After reset the status word reads 0x001: bit 0 (lockstep) is 1 and every other bit is 0. Both error outputs, both inject outputs and the NMI output are 0.
- R2: A write to address 0 with bit 1 set starts an accepted self-test. The active flag (status bit 3) is 1 from the cycle after that write. It returns to 0 in the same cycle that the done flag (status bit 4) becomes 1.
- R3: The self-test asserts inject_1 first and then inject_2. Each step passes if that comparator's mismatch is seen within TIMEOUT cycles (default 4) of the step's start, and fails otherwise. A failed first step ends the run without asserting inject_2. The done flag (bit 4) is set at the end of every run. The pass flag (bit 5) is set only when both steps pass.
- R4: A write to address 0 with bit 2 (comparator 1) or bit 3 (comparator 2) set starts an accepted error-force run. That comparator's error output is 1 for exactly the cycle after the write. On the next edge its done flag (bit 6 or 8) and its pass flag (bit 7 or 9) are set, and the NMI output pulses for one cycle.
- R5: Self-test and error-force starts are ignored while any of these holds: compare fail (bit 1) is set; a done flag is set with its pass flag clear; or compare enable is 0. Compare enable is bit 0 of the last write to address 0. Error-force starts are also ignored while the debugger flag (bit 2) is set.
- R6: A start is ignored while the done flag or the pass flag of that same test is still set.
- R7: Compare fail (bit 1) latches on a mismatch from either comparator when all of these hold: compare enable is 1, the lockstep bit is 1 and the debugger flag is 0. It is never set by mismatches during a self-test or an error-force pulse. Only reset or a clear write resets it. While it latches, the matching error output pulses.
- R8: A write to address 1 clears flags as follows: bit 0 clears compare fail, bits 1 and 2 clear self-test done and pass, bits 3 and 4 clear force-1 done and pass, and bits 5 and 6 clear force-2 done and pass. A clear wins over a hardware set in the same cycle.
- R9: The debugger flag (bit 2) latches on debug_attached and only reset clears it. While the flag is set, compare fail is not latched, but a self-test still runs and can pass.
- R10: The lockstep bit (bit 0) takes the value of the strap one cycle later, resets to 1, and does not depend on the debugger flag.
- R11: rd_data shows, one cycle after rd_addr is applied, the compare-enable bit for address 0, the status word for address 2, and 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0 control, 1 clear) |
| wr_data | input | 7 | Write data |
| rd_addr | input | ADDR_W | Read address (0 control, 2 status) |
| rd_data | output | 10 | Registered read data |
| lockstep_strap | input | 1 | Lockstep-mode strap from system control |
| debug_attached | input | 1 | Debugger-connected indication |
| mismatch_1 | input | 1 | Raw mismatch from comparator 1 |
| mismatch_2 | input | 1 | Raw mismatch from comparator 2 |
| inject_1 | output | 1 | Self-test mismatch injection into comparator 1 |
| inject_2 | output | 1 | Self-test mismatch injection into comparator 2 |
| status_word | output | 10 | Status flags |
| nmi_pulse | output | 1 | One-cycle NMI on a passing error-force run |
| cmp_err_1 | output | 1 | Comparator 1 error to system control |
| cmp_err_2 | output | 1 | Comparator 2 error to system control |

## Verification
The self-test is run with the bench's comparator model answering after every pair of delays from 0 to 5 cycles. Delays up to 3 must pass, and the run must end on the exact edge the window arithmetic gives. A delay of 4 or 5 separates a first-step abort, where inject_2 never rises, from a second-step fail. Error-force runs, clears issued on the same edge as the hardware set, mismatches driven in each gating state, and a debugger attach each exercise a different gating or priority path.

// File: rtl/lss_pkg.sv
package lss_pkg;
  localparam int N_CMP  = 2;
  localparam int CLR_W  = 3 + 2 * N_CMP;
  localparam int STAT_W = 6 + 2 * N_CMP;

  // write/read addresses
  localparam int A_CTRL = 0;
  localparam int A_CLR  = 1;
  localparam int A_STAT = 2;

  // control write bits
  localparam int C_EN    = 0;
  localparam int C_START = 1;
  localparam int C_FORCE = 2;   // + comparator index

  // clear write bits
  localparam int K_FAIL   = 0;
  localparam int K_STDONE = 1;
  localparam int K_STPASS = 2;
  localparam int K_FORCE  = 3;  // + 2*index (done), +1 (pass)

  // status bits
  localparam int S_LOCK   = 0;
  localparam int S_FAIL   = 1;
  localparam int S_DBG    = 2;
  localparam int S_ACTIVE = 3;
  localparam int S_STDONE = 4;
  localparam int S_STPASS = 5;
  localparam int S_FORCE  = 6;  // + 2*index (done), +1 (pass)

  typedef enum logic [1:0] {ST_IDLE, ST_STEP1, ST_STEP2} st_state_e;
endpackage

// File: rtl/lss_selftest.sv
module lss_selftest
  import lss_pkg::*;
#(
  parameter int TIMEOUT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mis_1,
  input  logic mis_2,
  input  logic clr_done,
  input  logic clr_pass,
  output logic active,
  output logic done,
  output logic pass,
  output logic inj_1,
  output logic inj_2
);
  localparam int TMR_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  st_state_e        state, state_n;
  logic [TMR_W-1:0] tmr, tmr_n;
  logic             fin, ok;

  always_comb begin
    state_n = state;
    tmr_n   = tmr;
    fin     = 1'b0;
    ok      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          state_n = ST_STEP1;
          tmr_n   = '0;
        end
      end
      ST_STEP1: begin
        if (mis_1) begin
          state_n = ST_STEP2;
          tmr_n   = '0;
        end else if (tmr == TMR_LAST) begin
          state_n = ST_IDLE;
          fin     = 1'b1;
        end else begin
          tmr_n = tmr + 1'b1;
        end
      end
      ST_STEP2: begin
        if (mis_2) begin
          state_n = ST_IDLE;
          fin     = 1'b1;
          ok      = 1'b1;
        end else if (tmr == TMR_LAST) begin
          state_n = ST_IDLE;
          fin     = 1'b1;
        end else begin
          tmr_n = tmr + 1'b1;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tmr   <= '0;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      state <= state_n;
      tmr   <= tmr_n;
      if (clr_done)  done <= 1'b0;
      else if (fin)  done <= 1'b1;
      if (clr_pass)      pass <= 1'b0;
      else if (fin & ok) pass <= 1'b1;
    end
  end

  assign active = (state != ST_IDLE);
  assign inj_1  = (state == ST_STEP1);
  assign inj_2  = (state == ST_STEP2);

  assert_active_ends_with_done_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (!active && $past(active)));
  assert_step_order_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(inj_2) |-> $past(inj_1));
  assert_pass_implies_done_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(pass) |-> (done || $past(clr_done)));
endmodule

// File: rtl/lss_force_unit.sv
module lss_force_unit (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic err_in,
  input  logic clr_done,
  input  logic clr_pass,
  output logic pulse,
  output logic done,
  output logic pass,
  output logic nmi
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      done  <= 1'b0;
      pass  <= 1'b0;
      nmi   <= 1'b0;
    end else begin
      pulse <= start;
      nmi   <= pulse & err_in;
      if (clr_done)   done <= 1'b0;
      else if (pulse) done <= 1'b1;
      if (clr_pass)            pass <= 1'b0;
      else if (pulse & err_in) pass <= 1'b1;
    end
  end

  assert_single_cycle_force_R4: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  assert_single_cycle_nmi_R4: assert property (@(posedge clk) disable iff (rst)
    nmi |=> !nmi);
endmodule

// File: rtl/lss_cmp_monitor.sv
module lss_cmp_monitor
  import lss_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             strap,
  input  logic             dbg_attach,
  input  logic             cmp_en,
  input  logic [N_CMP-1:0] mis,
  input  logic             testing,
  input  logic             clr_fail,
  output logic             lockstep,
  output logic             dbg,
  output logic             cmp_fail,
  output logic [N_CMP-1:0] err
);
  logic cmp_on;
  assign cmp_on = cmp_en & lockstep & ~dbg & ~testing;

  always_ff @(posedge clk) begin
    if (rst) begin
      lockstep <= 1'b1;
      dbg      <= 1'b0;
      cmp_fail <= 1'b0;
    end else begin
      lockstep <= strap;
      dbg      <= dbg | dbg_attach;
      if (clr_fail)                cmp_fail <= 1'b0;
      else if (cmp_on && (|mis))   cmp_fail <= 1'b1;
    end
  end

  for (genvar i = 0; i < N_CMP; i++) begin : g_err
    always_ff @(posedge clk) begin
      if (rst) err[i] <= 1'b0;
      else     err[i] <= cmp_on & mis[i];
    end
  end

  assert_no_fail_in_test_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_fail) |-> $past(!testing));
  assert_fail_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
    clr_fail |=> !cmp_fail);
  assert_dbg_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    dbg |=> dbg);
  assert_no_fail_with_dbg_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(cmp_fail) |-> $past(!dbg));
endmodule

// File: rtl/lockstep_supervisor.sv
module lockstep_supervisor
  import lss_pkg::*;
#(
  parameter int TIMEOUT = 4,
  parameter int ADDR_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CLR_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [STAT_W-1:0] rd_data,
  input  logic              lockstep_strap,
  input  logic              debug_attached,
  input  logic              mismatch_1,
  input  logic              mismatch_2,
  output logic              inject_1,
  output logic              inject_2,
  output logic [STAT_W-1:0] status_word,
  output logic              nmi_pulse,
  output logic              cmp_err_1,
  output logic              cmp_err_2
);
  logic wr_ctrl, wr_clr;
  logic cmp_en;
  logic st_active, st_done, st_pass, st_req, st_go;
  logic lockstep, dbg, cmp_fail, pending;
  logic [N_CMP-1:0] mis, mon_err, f_pulse, f_done, f_pass, f_nmi, f_go, err_out;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign wr_clr  = wr_en && (wr_addr == ADDR_W'(A_CLR));
  assign mis     = {mismatch_2, mismatch_1};

  always_ff @(posedge clk) begin
    if (rst)          cmp_en <= 1'b0;
    else if (wr_ctrl) cmp_en <= wr_data[C_EN];
  end

  assign pending = cmp_fail | (st_done & ~st_pass) | (|(f_done & ~f_pass));
  assign st_req  = wr_ctrl & wr_data[C_START];
  assign st_go   = st_req & ~pending & cmp_en & ~st_done & ~st_pass & ~st_active;

  lss_selftest #(.TIMEOUT(TIMEOUT)) u_selftest (
    .clk      (clk),
    .rst      (rst),
    .start    (st_go),
    .mis_1    (mismatch_1),
    .mis_2    (mismatch_2),
    .clr_done (wr_clr & wr_data[K_STDONE]),
    .clr_pass (wr_clr & wr_data[K_STPASS]),
    .active   (st_active),
    .done     (st_done),
    .pass     (st_pass),
    .inj_1    (inject_1),
    .inj_2    (inject_2)
  );

  for (genvar i = 0; i < N_CMP; i++) begin : g_force
    assign f_go[i] = wr_ctrl & wr_data[C_FORCE+i] & ~pending & cmp_en & ~dbg
                     & ~f_done[i] & ~f_pass[i] & ~st_active & ~(|f_pulse);
    assign err_out[i] = f_pulse[i] | mon_err[i];

    lss_force_unit u_force (
      .clk      (clk),
      .rst      (rst),
      .start    (f_go[i]),
      .err_in   (err_out[i]),
      .clr_done (wr_clr & wr_data[K_FORCE+2*i]),
      .clr_pass (wr_clr & wr_data[K_FORCE+2*i+1]),
      .pulse    (f_pulse[i]),
      .done     (f_done[i]),
      .pass     (f_pass[i]),
      .nmi      (f_nmi[i])
    );

    assign status_word[S_FORCE+2*i]   = f_done[i];
    assign status_word[S_FORCE+2*i+1] = f_pass[i];
  end

  lss_cmp_monitor u_monitor (
    .clk        (clk),
    .rst        (rst),
    .strap      (lockstep_strap),
    .dbg_attach (debug_attached),
    .cmp_en     (cmp_en),
    .mis        (mis),
    .testing    (st_active | (|f_pulse)),
    .clr_fail   (wr_clr & wr_data[K_FAIL]),
    .lockstep   (lockstep),
    .dbg        (dbg),
    .cmp_fail   (cmp_fail),
    .err        (mon_err)
  );

  assign status_word[S_LOCK]   = lockstep;
  assign status_word[S_FAIL]   = cmp_fail;
  assign status_word[S_DBG]    = dbg;
  assign status_word[S_ACTIVE] = st_active;
  assign status_word[S_STDONE] = st_done;
  assign status_word[S_STPASS] = st_pass;

  assign nmi_pulse = |f_nmi;
  assign cmp_err_1 = err_out[0];
  assign cmp_err_2 = err_out[1];

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_addr == ADDR_W'(A_CTRL)) rd_data <= STAT_W'(cmp_en);
    else if (rd_addr == ADDR_W'(A_STAT)) rd_data <= status_word;
    else rd_data <= '0;
  end

  assert_gated_start_R5: assert property (@(posedge clk) disable iff (rst)
    (st_req && pending && !st_active) |=> !st_active);
  assert_rerun_needs_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (st_req && st_done && !st_active) |=> !st_active);
  assert_force_blocked_dbg_R5: assert property (@(posedge clk) disable iff (rst)
    (dbg && !(|f_pulse)) |=> !(|f_pulse));
endmodule

// File: tb/lockstep_supervisor_tb.sv
module lockstep_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 4;
  // status bit positions (from requirements)
  localparam int B_LOCK = 0, B_FAIL = 1, B_DBG = 2, B_ACT = 3, B_SD = 4, B_SP = 5;
  localparam int B_F1D = 6, B_F1P = 7, B_F2D = 8, B_F2P = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [9:0] rd_data, status_word;
  logic strap = 1'b1, dbg_att = 1'b0;
  logic mis1_f = 1'b0, mis2_f = 1'b0;
  logic mismatch_1, mismatch_2, inject_1, inject_2, nmi_pulse, cmp_err_1, cmp_err_2;

  int checks = 0, errors = 0;
  int d1 = 0, d2 = 0, cnt1 = 0, cnt2 = 0, inj2_cnt = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // comparator model: reports an injected mismatch after a programmable delay
  always @(posedge clk) begin
    cnt1 <= inject_1 ? cnt1 + 1 : 0;
    cnt2 <= inject_2 ? cnt2 + 1 : 0;
    if (inject_2) inj2_cnt <= inj2_cnt + 1;
  end
  assign mismatch_1 = (inject_1 && cnt1 >= d1) || mis1_f;
  assign mismatch_2 = (inject_2 && cnt2 >= d2) || mis2_f;

  lockstep_supervisor #(.TIMEOUT(TO), .ADDR_W(2)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lockstep_strap(strap),
    .debug_attached(dbg_att), .mismatch_1(mismatch_1), .mismatch_2(mismatch_2),
    .inject_1(inject_1), .inject_2(inject_2), .status_word(status_word),
    .nmi_pulse(nmi_pulse), .cmp_err_1(cmp_err_1), .cmp_err_2(cmp_err_2)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [6:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic run_selftest(input int a, input int b);
    int n, base;
    bit ok;
    d1 = a; d2 = b;
    base = inj2_cnt;
    ok = (a < TO) && (b < TO);
    n = (a >= TO) ? TO : ((b >= TO) ? a + 1 + TO : a + b + 2);
    wr(2'd0, 7'h03);
    chk("R2 active after start", status_word[B_ACT], 1);
    repeat (n - 1) step();
    chk("R2 active before end", status_word[B_ACT], 1);
    chk("R3 done before end", status_word[B_SD], 0);
    step();
    chk("R2 active falls with done", status_word[B_ACT], 0);
    chk("R3 done at end", status_word[B_SD], 1);
    chk("R3 pass result", status_word[B_SP], ok);
    chk("R7 no fail from test", status_word[B_FAIL], 0);
    if (a >= TO) chk("R3 step2 skipped", inj2_cnt - base, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    chk("R1 status", status_word, 10'h001);
    chk("R1 outputs", {cmp_err_1, cmp_err_2, inject_1, inject_2, nmi_pulse}, 0);
    chk("R1 rd_data", rd_data, 0);

    // R10 strap follow
    strap = 1'b0; step();
    chk("R10 strap low", status_word[B_LOCK], 0);
    strap = 1'b1; step();
    chk("R10 strap high", status_word[B_LOCK], 1);

    // R5 compare disabled: starts ignored
    wr(2'd0, 7'h02);
    chk("R5 st ignored when disabled", status_word[B_ACT], 0);
    wr(2'd0, 7'h04);
    chk("R5 force ignored when disabled", cmp_err_1, 0);
    step();
    chk("R5 force done stays 0", status_word[B_F1D], 0);

    // enable, R11 readback
    wr(2'd0, 7'h01);
    rd_addr = 2'd0; step();
    chk("R11 ctrl readback", rd_data, 1);
    rd_addr = 2'd2; step();
    chk("R11 status readback", rd_data, 10'h001);
    rd_addr = 2'd3; step();
    chk("R11 unmapped reads 0", rd_data, 0);

    // R2/R3 delay sweep
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        run_selftest(a, b);
        wr(2'd1, 7'h06);
        chk("R8 clears st flags", {status_word[B_SD], status_word[B_SP]}, 0);
      end
    end

    // R6 rerun needs clear
    run_selftest(0, 0);
    wr(2'd0, 7'h03);
    chk("R6 rerun blocked", status_word[B_ACT], 0);
    wr(2'd1, 7'h02);
    wr(2'd0, 7'h03);
    chk("R6 rerun blocked by pass", status_word[B_ACT], 0);
    wr(2'd1, 7'h04);
    run_selftest(1, 2);
    wr(2'd1, 7'h06);

    // R4 error force on each comparator
    wr(2'd0, 7'h05);
    chk("R4 err1 pulse", {cmp_err_1, cmp_err_2, nmi_pulse}, 3'b100);
    step();
    chk("R4 err1 one cycle", cmp_err_1, 0);
    chk("R4 f1 done/pass", {status_word[B_F1D], status_word[B_F1P]}, 2'b11);
    chk("R4 nmi pulse", nmi_pulse, 1);
    step();
    chk("R4 nmi one cycle", nmi_pulse, 0);
    wr(2'd0, 7'h09);
    chk("R4 err2 pulse", {cmp_err_1, cmp_err_2}, 2'b01);
    step();
    chk("R4 f2 done/pass", {status_word[B_F2D], status_word[B_F2P], nmi_pulse}, 3'b111);
    step();
    // R6 force rerun without clear
    wr(2'd0, 7'h05);
    chk("R6 force rerun blocked", cmp_err_1, 0);
    step();
    chk("R6 no nmi", nmi_pulse, 0);
    wr(2'd1, 7'h78);
    chk("R8 force clears", status_word[9:6], 0);

    // R5 pending failed self-test blocks starts
    run_selftest(5, 0);
    wr(2'd0, 7'h05);
    chk("R5 force blocked by failed test", cmp_err_1, 0);
    wr(2'd0, 7'h03);
    chk("R5 st blocked by failed test", status_word[B_ACT], 0);
    wr(2'd1, 7'h06);

    // R8 clear wins over set (force)
    wr(2'd0, 7'h09);
    wr(2'd1, 7'h20);
    chk("R8 f2 done clear wins", status_word[B_F2D], 0);
    chk("R8 f2 pass kept", status_word[B_F2P], 1);
    wr(2'd1, 7'h40);

    // R8 clear wins over set (self-test, done edge is 2nd after start)
    d1 = 0; d2 = 0;
    wr(2'd0, 7'h03);
    step();
    wr(2'd1, 7'h02);
    chk("R8 st done clear wins", {status_word[B_ACT], status_word[B_SD], status_word[B_SP]}, 3'b001);
    wr(2'd1, 7'h04);

    // R7 compare fail latch
    mis1_f = 1'b1; step();
    chk("R7 fail latched", status_word[B_FAIL], 1);
    chk("R7 err1 pulse", cmp_err_1, 1);
    mis1_f = 1'b0; step();
    chk("R7 fail held", {status_word[B_FAIL], cmp_err_1}, 2'b10);
    wr(2'd0, 7'h03);
    chk("R5 st blocked by fail", status_word[B_ACT], 0);
    wr(2'd1, 7'h01);
    chk("R8 fail cleared", status_word[B_FAIL], 0);
    mis2_f = 1'b1;
    wr(2'd1, 7'h01);
    mis2_f = 1'b0;
    chk("R8 fail clear wins", status_word[B_FAIL], 0);
    step();
    chk("R8 fail stays clear", status_word[B_FAIL], 0);
    wr(2'd0, 7'h00);
    mis1_f = 1'b1; step(); mis1_f = 1'b0;
    chk("R7 no fail when disabled", {status_word[B_FAIL], cmp_err_1}, 0);
    wr(2'd0, 7'h01);

    // R9 debugger
    dbg_att = 1'b1; step(); dbg_att = 1'b0; step();
    chk("R9 dbg latched", status_word[B_DBG], 1);
    wr(2'd1, 7'h7F);
    chk("R9 dbg not cleared", status_word[B_DBG], 1);
    mis1_f = 1'b1; step(); mis1_f = 1'b0;
    chk("R9 no fail with dbg", status_word[B_FAIL], 0);
    wr(2'd0, 7'h05);
    chk("R5 force blocked by dbg", cmp_err_1, 0);
    step();
    chk("R5 no force done with dbg", status_word[B_F1D], 0);
    run_selftest(0, 1);
    chk("R10 lockstep with dbg", status_word[B_LOCK], 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule